// File: doc/BRIEF.md
# Write-Masked GPIO Port Register File

This block is the register side of a 32-pin general-purpose I/O port that sits on a simple memory-mapped 32-bit bus. Each pin-wide control register is stored as two 16-bit halves. The half that covers pins 0 to 15 sits at the register's base offset, and the half that covers pins 16 to 31 sits at base plus 4. In every write to a half, the upper 16 bits of the bus word act as per-bit write enables for the lower 16 data bits. Software can therefore set or clear a single pin in one bus write, with no read-modify-write sequence and no lock.

The output-data register drives the pin output levels. The direction register drives the per-pin output enables. The interrupt, edge, polarity, debounce and end-of-interrupt registers are kept only as storage for logic that lives outside this block. Pin inputs pass through a two-flop synchronizer into a read-only port-level register that returns all 32 pins in one read. A constant identification word can also be read.

The bus is single-cycle. A write is taken on the rising clock edge while `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_halfmask_port`

## Requirements
- R1: For each masked register, the pins 0-15 half is at the base offset and the pins 16-31 half is at base+4. A read of either half returns that half's 16 data bits in bits 15:0, with bits 31:16 read as zero.
- R2: A write to a masked half sets data bit i (i = 0..15) to written bit i only when written bit i+16 is 1. Data bits whose enable is 0 keep their value.
- R3: A write whose upper 16 bits are all zero changes no register and no pin output.
- R4: `pin_oe` equals the direction register (base 0x08), where 1 makes the pin an output and 0 makes it an input. It changes only through writes to offsets 0x08 and 0x0C.
- R5: `pin_out` equals the output-data register (base 0x00). It changes only through writes to offsets 0x00 and 0x04.
- R6: A read at 0x70 returns all 32 pin levels. A change on `pin_in` first shows there after the second rising clock edge that follows it.
- R7: A read at 0x78 returns 0x01000C2B.
- R8: After reset, every masked register reads 0, and both `pin_out` and `pin_oe` are 0.
- R9: Writes to the read-only offsets (0x50, 0x58, 0x70, 0x78) change no register and no output.
- R10: Reads of 0x50, 0x58, 0x74, 0x7C, 0x68/0x6C and every offset from 0x80 up return 0.
- R11: The eleven masked registers are independent. Their bases are 0x00, 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38, 0x40, 0x48 and 0x60, and a write to one half of one register leaves every other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write word: [31:16] enables, [15:0] data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |

## Verification
A wrong stored bit in the output-data or direction register is visible on `pin_out` or `pin_oe` one edge after the faulty write. A wrong stored bit in any other register is visible only when that half is read back. This is why the bench reads every half after each scenario. A decode that is off by one slot or by one half corrupts a neighbouring register, and the independence check finds it on the next full read-back. An error in the synchronizer depth moves the port-level read by one cycle, so that read is sampled both one edge and two edges after an input change.

// File: rtl/gpio_hm_pkg.sv
package gpio_hm_pkg;
  localparam int PIN_W     = 32;
  localparam int HALF_W    = PIN_W / 2;
  localparam int ADDR_W    = 8;
  localparam int NUM_STORE = 11;
  localparam int IDX_W     = $clog2(NUM_STORE);

  // Slot = address bits [7:3]; bit 2 picks the half
  localparam int LAST_PLAIN_SLOT = 9;
  localparam int EOI_SLOT        = 12;
  localparam int EXT_SLOT        = 14;
  localparam int VER_SLOT        = 15;
  localparam int EOI_IDX         = 10;
  localparam logic [31:0] VERSION_WORD = 32'h0100_0C2B;

  typedef enum logic [1:0] {
    ACC_STORE = 2'd0,
    ACC_EXT   = 2'd1,
    ACC_VER   = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             hi;
  } acc_dec_t;

  // New half value: enable bits come from the upper halfword of the bus word
  function automatic logic [HALF_W-1:0] merge_masked(input logic [HALF_W-1:0] old_v,
                                                     input logic [2*HALF_W-1:0] word);
    logic [HALF_W-1:0] en;
    en = word[2*HALF_W-1:HALF_W];
    return (old_v & ~en) | (word[HALF_W-1:0] & en);
  endfunction

  function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a);
    acc_dec_t d;
    int unsigned slot;
    slot   = int'(a[ADDR_W-1:3]);
    d.hi   = a[2];
    d.idx  = '0;
    d.kind = ACC_NONE;
    if (slot <= LAST_PLAIN_SLOT) begin
      d.kind = ACC_STORE;
      d.idx  = IDX_W'(slot);
    end else if (slot == EOI_SLOT) begin
      d.kind = ACC_STORE;
      d.idx  = IDX_W'(EOI_IDX);
    end else if (slot == EXT_SLOT && !a[2]) begin
      d.kind = ACC_EXT;
    end else if (slot == VER_SLOT && !a[2]) begin
      d.kind = ACC_VER;
    end
    return d;
  endfunction
endpackage

// File: rtl/gpio_hm_decode.sv
module gpio_hm_decode
  import gpio_hm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output acc_dec_t          dec
);
  always_comb dec = decode_addr(addr);
endmodule

// File: rtl/gpio_hm_half.sv
module gpio_hm_half
  import gpio_hm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [2*HALF_W-1:0] word,
  output logic [HALF_W-1:0]   q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= merge_masked(q, word);
  end
endmodule

// File: rtl/gpio_hm_sync.sv
module gpio_hm_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_halfmask_port.sv
module gpio_halfmask_port
  import gpio_hm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  localparam int DATA_IDX = 0;
  localparam int DIR_IDX  = 1;

  acc_dec_t          dec;
  logic              wr_fire;
  logic              store_hit;
  logic [PIN_W-1:0]  store_q [NUM_STORE];
  logic [PIN_W-1:0]  ext_q;
  logic [HALF_W-1:0] sel_half;

  gpio_hm_decode u_dec (.addr(bus_addr), .dec(dec));

  assign wr_fire   = bus_sel && bus_wr;
  assign store_hit = (dec.kind == ACC_STORE);

  for (genvar r = 0; r < NUM_STORE; r++) begin : g_reg
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic we_h;
      assign we_h = wr_fire && store_hit && (dec.idx == IDX_W'(r)) && (dec.hi == 1'(h));
      gpio_hm_half u_half (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we_h),
        .word (bus_wdata),
        .q    (store_q[r][h*HALF_W +: HALF_W])
      );
    end
  end

  gpio_hm_sync #(.W(PIN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(ext_q)
  );

  assign sel_half = dec.hi ? store_q[dec.idx][PIN_W-1:HALF_W]
                           : store_q[dec.idx][HALF_W-1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (dec.kind)
        ACC_STORE: bus_rdata = {{(32-HALF_W){1'b0}}, sel_half};
        ACC_EXT:   bus_rdata = ext_q;
        ACC_VER:   bus_rdata = VERSION_WORD;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = store_q[DATA_IDX];
  assign pin_oe  = store_q[DIR_IDX];
endmodule

// File: rtl/gpio_hm_checker.sv
module gpio_hm_checker
  import gpio_hm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [PIN_W-1:0]  pin_in,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe
);
  logic [1:0] since_rst;
  logic       wr, rd, ro_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  assign wr = bus_sel && bus_wr;
  assign rd = bus_sel && !bus_wr;
  assign ro_addr = (bus_addr == 8'h50) || (bus_addr == 8'h58) ||
                   (bus_addr == 8'h70) || (bus_addr == 8'h78);

  assert_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr != 8'h70 && bus_addr != 8'h78 |-> bus_rdata[31:16] == 16'h0);

  assert_lo_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == 8'h00 |=>
      pin_out[15:0] == merge_masked($past(pin_out[15:0]), $past(bus_wdata)));

  assert_hi_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == 8'h0C |=>
      pin_oe[31:16] == merge_masked($past(pin_oe[31:16]), $past(bus_wdata)));

  assert_nomask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_wdata[31:16] == 16'h0 |=> $stable(pin_out) && $stable(pin_oe));

  assert_oe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr[7:3] != 5'd1 |=> $stable(pin_oe));

  assert_out_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr[7:3] != 5'd0 |=> $stable(pin_out));

  assert_ext_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst == 2 && rd && bus_addr == 8'h70 |-> bus_rdata == $past(pin_in, 2));

  assert_version_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == 8'h78 |-> bus_rdata == 32'h0100_0C2B);

  assert_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pin_out == '0 && pin_oe == '0);

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr && ro_addr |=> $stable(pin_out) && $stable(pin_oe));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr[7] |-> bus_rdata == 32'h0);
endmodule

bind gpio_halfmask_port gpio_hm_checker u_chk (.*);

// File: tb/gpio_halfmask_port_bench.sv
module gpio_halfmask_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [11];
  logic [7:0]  bases [11] = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h20, 8'h28,
                               8'h30, 8'h38, 8'h40, 8'h48, 8'h60};

  always #5 clk = ~clk;

  gpio_halfmask_port u_gpio_halfmask_port (.*);

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  // Bench model of one masked write, bit by bit
  task automatic mwrite(int r, bit hi, logic [31:0] d);
    for (int i = 0; i < 16; i++)
      if (d[16+i]) model[r][(hi ? 16 : 0) + i] = d[i];
    wr(bases[r] + (hi ? 8'h4 : 8'h0), d);
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    for (int r = 0; r < 11; r++) begin
      rd(bases[r], v);       check(req, v, {16'h0, model[r][15:0]});
      rd(bases[r] + 8'h4, v); check(req, v, {16'h0, model[r][31:16]});
    end
    @(negedge clk);
    check(req, pin_out, model[0]);
    check(req, pin_oe, model[1]);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 11; r++) model[r] = '0;
    check_all("R8");
  endtask

  task automatic t_halves;
    mwrite(0, 0, 32'hFFFF_1234);
    mwrite(0, 1, 32'hFFFF_ABCD);
    check("R1", pin_out, 32'hABCD_1234);
    check_all("R1/R5");
  endtask

  task automatic t_mask;
    mwrite(0, 0, 32'h0004_0000);          // clear bit 2 only
    check("R2", pin_out, 32'hABCD_1230);
    mwrite(0, 1, 32'h8003_0003);          // set bits 16,17 and clear 31
    check("R2", pin_out, 32'h2BCF_1230);
    mwrite(0, 0, 32'h0000_FFFF);          // no enables
    check("R3", pin_out, 32'h2BCF_1230);
    check_all("R2/R3");
  endtask

  task automatic t_dir;
    mwrite(1, 0, 32'h00FF_00FF);
    mwrite(1, 1, 32'hF000_F000);
    check("R4", pin_oe, 32'hF000_00FF);
    check("R5", pin_out, 32'h2BCF_1230);
  endtask

  task automatic t_indep;
    for (int r = 2; r < 11; r++) begin
      mwrite(r, 0, {16'hFFFF, 16'(r * 16'h1111)});
      mwrite(r, 1, {16'h0F0F, 16'(~(r * 16'h0101))});
    end
    check_all("R11");
  endtask

  task automatic t_ro;
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    check_all("R9");
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    logic [7:0] list [8] = '{8'h50, 8'h58, 8'h68, 8'h6C, 8'h74, 8'h7C, 8'h80, 8'hFC};
    for (int k = 0; k < 8; k++) begin
      rd(list[k], v);
      check("R10", v, 32'h0);
    end
  endtask

  task automatic t_version;
    logic [31:0] v;
    rd(8'h78, v);
    check("R7", v, 32'h0100_0C2B);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    @(negedge clk) pin_in = 32'hDEAD_BEEF;
    @(negedge clk); repeat (2) @(negedge clk);
    rd(8'h70, v); check("R6", v, 32'hDEAD_BEEF);
    @(negedge clk) pin_in = 32'h1357_9BDF;   // change before edge e1
    @(posedge clk);                           // e1
    #1 bus_sel = 1; bus_wr = 0; bus_addr = 8'h70;
    @(negedge clk) check("R6 after one edge", bus_rdata, 32'hDEAD_BEEF);
    @(posedge clk);                           // e2
    @(negedge clk) check("R6 after two edges", bus_rdata, 32'h1357_9BDF);
    bus_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_halves();
    t_mask();
    t_dir();
    t_indep();
    t_ro();
    t_unmapped();
    t_version();
    t_ext();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule